// File: doc/BRIEF.md
# Neighbour-Guided Macroblock Mode Selector

This block chooses the coding mode of one macroblock at a time while asking an external cost engine for as few rate-distortion costs as it can. A macroblock is handed over as a column/row position inside a frame whose size in macroblocks is given on plain control pins. The selector then names one candidate mode at a time on a request stream and collects the cost of that candidate on a response stream. It finishes by presenting the chosen mode and its cost on a result stream.

The order of decisions is fixed. Skip is always priced first and is taken at once when its cost is under a programmable threshold. A macroblock on the top row or left column prices every mode. Elsewhere the selector first trusts agreement among the left, above and above-right neighbours of the current frame. It then trusts agreement between the blocks below and to the right in the previous frame. If neither is trusted, it prices every mode not yet priced. The chosen mode and cost of each macroblock are kept in one of two frame stores, and a frame-start pulse swaps which store is current and which holds the previous frame.

All three streams use valid/ready. Once a request is raised, its mode stays fixed until it is accepted. Responses are taken only while `rsp_ready` is high, and the selector keeps one request in flight at a time. A result stays on the port until `res_ready` is seen. A new macroblock is accepted only while `start_ready` is high, which happens only when the selector is idle.

Top module: `mb_mode_selector`

## Requirements
- R1: The first request for every macroblock names skip. If the skip cost is strictly less than `skip_thresh`, skip is the result with that cost and no other mode is requested.
- R2: When skip is not taken and the macroblock has column 0 or row 0, all seven modes are requested and the cheapest is the result. On equal costs the lower mode code wins.
- R3: Otherwise, when the above-right position lies inside the frame and the left, above and above-right entries of the current-frame store hold one mode M, M is requested if it has not been requested yet. M is the result when its cost is strictly less than floor((sum of the three stored costs)/3).
- R4: If R3 gives no result, and both the position one row below and the position one column right lie inside the frame, the previous-frame entries at those two positions are compared. When they hold one mode M, M is requested if not yet requested, and it is the result when its cost is strictly less than floor((sum of the two stored costs)/2).
- R5: If no earlier step gives a result, every mode not yet requested is requested and the cheapest of all seven is the result, with ties going to the lower code.
- R6: No mode is requested twice for one macroblock.
- R7: Mode codes on `req_mode` and `res_mode` are 0 skip, 1 16x16, 2 16x8, 3 8x16, 4 8x8, 5 intra 4x4, 6 intra 16x16. Code 7 never appears.
- R8: The accepted result is written to the current-frame store at the macroblock's position. A `frame_start` pulse makes the current store the previous one. Before any result has been written, every store entry reads as skip with cost 0.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_mode` hold in the next cycle. The result is the same under any back-pressure pattern on `req_ready`.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_mode` and `res_cost` hold. After acceptance the block returns to idle with `start_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that swaps current and previous frame stores |
| frame_w | input | 5 | Frame width in macroblocks (1..22) |
| frame_h | input | 5 | Frame height in macroblocks (1..18) |
| skip_thresh | input | 16 | Skip acceptance threshold |
| start_valid | input | 1 | New macroblock offered |
| start_ready | output | 1 | Selector idle and able to take a macroblock |
| start_x | input | 5 | Macroblock column |
| start_y | input | 5 | Macroblock row |
| req_valid | output | 1 | Cost request valid |
| req_ready | input | 1 | Cost engine takes the request |
| req_mode | output | 3 | Mode to be priced |
| rsp_valid | input | 1 | Cost response valid |
| rsp_ready | output | 1 | Selector waiting for a cost |
| rsp_cost | input | 16 | Rate-distortion cost of the requested mode |
| res_valid | output | 1 | Decision valid |
| res_ready | input | 1 | Consumer takes the decision |
| res_mode | output | 3 | Chosen mode |
| res_cost | output | 16 | Cost of the chosen mode |

## Verification
The assertions take for granted that `frame_start` never arrives while a result is being accepted, that macroblocks of a frame are offered in raster order inside the declared frame size, and that the cost engine answers each request with exactly one response. The stimulus pulses `frame_start` only between macroblocks while the selector is idle, walks each frame row by row within `frame_w` by `frame_h`, and uses a cost-engine model that raises one response in the cycle after each accepted request. Frame size changes only at a frame boundary.

// File: rtl/mbsel_pkg.sv
package mbsel_pkg;
  localparam int NUM_MODES = 7;
  localparam int MODE_W    = 3;
  localparam int CODE_SPAN = 1 << MODE_W;

  typedef enum logic [MODE_W-1:0] {
    MD_SKIP    = 3'd0,
    MD_P16X16  = 3'd1,
    MD_P16X8   = 3'd2,
    MD_P8X16   = 3'd3,
    MD_P8X8    = 3'd4,
    MD_I4X4    = 3'd5,
    MD_I16X16  = 3'd6
  } mb_mode_e;
endpackage

// File: rtl/mbsel_div3.sv
// Truncating divide by three using a reciprocal multiply, exact for all W-bit inputs.
module mbsel_div3 #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] num,
  output logic [W-1:0] quo
);
  localparam int     SH   = W + 1;
  localparam longint KL   = ((longint'(1) << SH) + 2) / 3;
  localparam logic [W-1:0] KMUL = KL[W-1:0];

  logic [2*W-1:0] prod;

  assign prod = {{W{1'b0}}, num} * {{W{1'b0}}, KMUL};
  assign quo  = {1'b0, prod[2*W-1:SH]};

  // R3: quotient is the truncated third of the input
  a_r3_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
    ({2'b0, quo} * 3 <= {2'b0, num}) && ({2'b0, num} < {2'b0, quo} * 3 + 3));
endmodule

// File: rtl/mbsel_store.sv
// Two mode/cost banks; one serves as current frame, the other as previous frame.
module mbsel_store #(
  parameter int CW    = 16,
  parameter int MAXW  = 22,
  parameter int MAXH  = 18,
  parameter int NRD   = 5,
  parameter int DEPTH = MAXW * MAXH,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      swap,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [2:0]                wr_mode,
  input  logic [CW-1:0]             wr_cost,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  input  logic [NRD-1:0]            rd_prev,
  output logic [NRD-1:0][2:0]       rd_mode,
  output logic [NRD-1:0][CW-1:0]    rd_cost
);
  localparam int EW = CW + 3;

  logic [EW-1:0] mem_q [2][DEPTH];
  logic          cur_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bank <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < DEPTH; i++)
          mem_q[b][i] <= '0;
    end else begin
      if (swap)  cur_bank <= ~cur_bank;
      if (wr_en) mem_q[cur_bank][wr_addr] <= {wr_mode, wr_cost};
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic          bank;
    logic [EW-1:0] ent;
    assign bank       = cur_bank ^ rd_prev[p];
    assign ent        = mem_q[bank][rd_addr[p]];
    assign rd_mode[p] = ent[EW-1:CW];
    assign rd_cost[p] = ent[CW-1:0];
  end

  // R8: a swap never coincides with a store write
  a_r8_swap_alone: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !wr_en);
endmodule

// File: rtl/mbsel_neigh.sv
// Neighbour addressing and shortcut qualification for one macroblock position.
module mbsel_neigh #(
  parameter int CW   = 16,
  parameter int MAXW = 22,
  parameter int MAXH = 18,
  parameter int XW   = $clog2(MAXW),
  parameter int YW   = $clog2(MAXH),
  parameter int FWW  = $clog2(MAXW + 1),
  parameter int FHW  = $clog2(MAXH + 1),
  parameter int AW   = $clog2(MAXW * MAXH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [XW-1:0]        pos_x,
  input  logic [YW-1:0]        pos_y,
  input  logic [FWW-1:0]       frame_w,
  input  logic [FHW-1:0]       frame_h,
  output logic [AW-1:0]        a_self,
  output logic [4:0][AW-1:0]   a_nb,
  input  logic [4:0][2:0]      nb_mode,
  input  logic [4:0][CW-1:0]   nb_cost,
  output logic                 at_edge,
  output logic                 spat_ok,
  output logic [2:0]           spat_mode,
  output logic [CW+1:0]        spat_thr,
  output logic                 temp_ok,
  output logic [2:0]           temp_mode,
  output logic [CW:0]          temp_thr
);
  // neighbour slots: 0 left, 1 above, 2 above-right (current); 3 below, 4 right (previous)
  logic [XW:0] xe, xp1, xm1;
  logic [YW:0] ye, yp1, ym1;
  logic        right_in, below_in;
  logic [CW+1:0] sum3;

  function automatic logic [AW-1:0] lin(input logic [XW:0] x, input logic [YW:0] y, input logic ok);
    lin = ok ? (AW'(y) * AW'(MAXW) + AW'(x)) : '0;
  endfunction

  assign xe  = {1'b0, pos_x};
  assign ye  = {1'b0, pos_y};
  assign xp1 = xe + 1'b1;
  assign xm1 = xe - 1'b1;
  assign yp1 = ye + 1'b1;
  assign ym1 = ye - 1'b1;

  assign right_in = xp1 < (XW+1)'(frame_w);
  assign below_in = yp1 < (YW+1)'(frame_h);
  assign at_edge  = (pos_x == '0) || (pos_y == '0);

  assign a_self  = lin(xe,  ye,  1'b1);
  assign a_nb[0] = lin(xm1, ye,  pos_x != '0);
  assign a_nb[1] = lin(xe,  ym1, pos_y != '0);
  assign a_nb[2] = lin(xp1, ym1, (pos_y != '0) && right_in);
  assign a_nb[3] = lin(xe,  yp1, below_in);
  assign a_nb[4] = lin(xp1, ye,  right_in);

  assign spat_ok   = !at_edge && right_in &&
                     (nb_mode[0] == nb_mode[1]) && (nb_mode[1] == nb_mode[2]);
  assign spat_mode = nb_mode[0];
  assign sum3      = {2'b0, nb_cost[0]} + {2'b0, nb_cost[1]} + {2'b0, nb_cost[2]};

  mbsel_div3 #(.W(CW + 2)) u_div3 (
    .clk  (clk),
    .rst_n(rst_n),
    .num  (sum3),
    .quo  (spat_thr)
  );

  logic [CW:0] sum2;
  assign sum2      = {1'b0, nb_cost[3]} + {1'b0, nb_cost[4]};
  assign temp_ok   = right_in && below_in && (nb_mode[3] == nb_mode[4]);
  assign temp_mode = nb_mode[3];
  assign temp_thr  = sum2 >> 1;
endmodule

// File: rtl/mb_mode_selector.sv
module mb_mode_selector
  import mbsel_pkg::*;
#(
  parameter int CW   = 16,
  parameter int MAXW = 22,
  parameter int MAXH = 18,
  parameter int XW   = $clog2(MAXW),
  parameter int YW   = $clog2(MAXH),
  parameter int FWW  = $clog2(MAXW + 1),
  parameter int FHW  = $clog2(MAXH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [FWW-1:0]  frame_w,
  input  logic [FHW-1:0]  frame_h,
  input  logic [CW-1:0]   skip_thresh,
  input  logic            start_valid,
  output logic            start_ready,
  input  logic [XW-1:0]   start_x,
  input  logic [YW-1:0]   start_y,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [2:0]      req_mode,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [CW-1:0]   rsp_cost,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [2:0]      res_mode,
  output logic [CW-1:0]   res_cost
);
  localparam int AW = $clog2(MAXW * MAXH);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_WAIT, ST_SKIPCHK, ST_SPAT, ST_TEMP, ST_FULL, ST_DONE
  } sel_state_e;

  sel_state_e st_q, ret_q;
  logic [XW-1:0]        x_q;
  logic [YW-1:0]        y_q;
  logic [2:0]           cur_q;
  logic [CODE_SPAN-1:0] tested_q;
  logic [CW-1:0]        mcost_q [CODE_SPAN];
  logic [2:0]           res_mode_q;
  logic [CW-1:0]        res_cost_q;

  // neighbour / store wiring
  logic [AW-1:0]         a_self;
  logic [4:0][AW-1:0]    a_nb;
  logic [4:0][2:0]       nb_mode;
  logic [4:0][CW-1:0]    nb_cost;
  logic                  at_edge, spat_ok, temp_ok;
  logic [2:0]            spat_mode, temp_mode;
  logic [CW+1:0]         spat_thr;
  logic [CW:0]           temp_thr;
  logic                  wr_en;

  mbsel_neigh #(.CW(CW), .MAXW(MAXW), .MAXH(MAXH)) u_neigh (
    .clk      (clk),
    .rst_n    (rst_n),
    .pos_x    (x_q),
    .pos_y    (y_q),
    .frame_w  (frame_w),
    .frame_h  (frame_h),
    .a_self   (a_self),
    .a_nb     (a_nb),
    .nb_mode  (nb_mode),
    .nb_cost  (nb_cost),
    .at_edge  (at_edge),
    .spat_ok  (spat_ok),
    .spat_mode(spat_mode),
    .spat_thr (spat_thr),
    .temp_ok  (temp_ok),
    .temp_mode(temp_mode),
    .temp_thr (temp_thr)
  );

  mbsel_store #(.CW(CW), .MAXW(MAXW), .MAXH(MAXH), .NRD(5)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .swap   (frame_start),
    .wr_en  (wr_en),
    .wr_addr(a_self),
    .wr_mode(res_mode_q),
    .wr_cost(res_cost_q),
    .rd_addr(a_nb),
    .rd_prev(5'b11000),
    .rd_mode(nb_mode),
    .rd_cost(nb_cost)
  );

  // first untested mode and cheapest tested mode
  logic          have_un, best_found;
  logic [2:0]    nxt_un, best_m;
  logic [CW-1:0] best_c;

  always_comb begin
    have_un = 1'b0;
    nxt_un  = '0;
    for (int i = NUM_MODES - 1; i >= 0; i--) begin
      if (!tested_q[i]) begin
        have_un = 1'b1;
        nxt_un  = 3'(i);
      end
    end
    best_found = 1'b0;
    best_m     = '0;
    best_c     = '0;
    for (int i = 0; i < NUM_MODES; i++) begin
      if (tested_q[i] && (!best_found || mcost_q[i] < best_c)) begin
        best_found = 1'b1;
        best_m     = 3'(i);
        best_c     = mcost_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ret_q      <= ST_IDLE;
      x_q        <= '0;
      y_q        <= '0;
      cur_q      <= '0;
      tested_q   <= '0;
      res_mode_q <= '0;
      res_cost_q <= '0;
      for (int i = 0; i < CODE_SPAN; i++) mcost_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_valid) begin
          x_q      <= start_x;
          y_q      <= start_y;
          tested_q <= '0;
          cur_q    <= MD_SKIP;
          ret_q    <= ST_SKIPCHK;
          st_q     <= ST_REQ;
        end
        ST_REQ: if (req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          mcost_q[cur_q]  <= rsp_cost;
          tested_q[cur_q] <= 1'b1;
          st_q            <= ret_q;
        end
        ST_SKIPCHK: begin
          if (mcost_q[MD_SKIP] < skip_thresh) begin
            res_mode_q <= MD_SKIP;
            res_cost_q <= mcost_q[MD_SKIP];
            st_q       <= ST_DONE;
          end else begin
            st_q <= at_edge ? ST_FULL : ST_SPAT;
          end
        end
        ST_SPAT: begin
          if (!spat_ok) begin
            st_q <= ST_TEMP;
          end else if (!tested_q[spat_mode]) begin
            cur_q <= spat_mode;
            ret_q <= ST_SPAT;
            st_q  <= ST_REQ;
          end else if ({2'b0, mcost_q[spat_mode]} < spat_thr) begin
            res_mode_q <= spat_mode;
            res_cost_q <= mcost_q[spat_mode];
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_TEMP;
          end
        end
        ST_TEMP: begin
          if (!temp_ok) begin
            st_q <= ST_FULL;
          end else if (!tested_q[temp_mode]) begin
            cur_q <= temp_mode;
            ret_q <= ST_TEMP;
            st_q  <= ST_REQ;
          end else if ({1'b0, mcost_q[temp_mode]} < temp_thr) begin
            res_mode_q <= temp_mode;
            res_cost_q <= mcost_q[temp_mode];
            st_q       <= ST_DONE;
          end else begin
            st_q <= ST_FULL;
          end
        end
        ST_FULL: begin
          if (have_un) begin
            cur_q <= nxt_un;
            ret_q <= ST_FULL;
            st_q  <= ST_REQ;
          end else begin
            res_mode_q <= best_m;
            res_cost_q <= best_c;
            st_q       <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign start_ready = (st_q == ST_IDLE);
  assign req_valid   = (st_q == ST_REQ);
  assign req_mode    = cur_q;
  assign rsp_ready   = (st_q == ST_WAIT);
  assign res_valid   = (st_q == ST_DONE);
  assign res_mode    = res_mode_q;
  assign res_cost    = res_cost_q;
  assign wr_en       = (st_q == ST_DONE) && res_ready;

  // R1: skip is always the first mode priced
  a_r1_skip_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tested_q == '0) |-> (req_mode == MD_SKIP));

  // R6: a mode already priced is never requested again
  a_r6_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !tested_q[req_mode]);

  // R2: a non-skip decision on the top row or left column follows a full pricing
  a_r2_edge_exhaustive: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && at_edge && res_mode != MD_SKIP) |-> (&tested_q[NUM_MODES-1:0]));

  // R7: only the seven defined codes leave the block
  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid |-> req_mode < 3'(NUM_MODES)) and (res_valid |-> res_mode < 3'(NUM_MODES)));

  // R9: a pending request holds its mode
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_mode)));

  // R10: a pending decision holds until taken
  a_r10_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mode) && $stable(res_cost)));

  // R5: a decision only ever reports a priced mode at its priced cost
  a_r5_priced_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (tested_q[res_mode] && mcost_q[res_mode] == res_cost));
endmodule

// File: tb/mb_mode_selector_test.sv
module mb_mode_selector_test;
  localparam int CW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [4:0]  frame_w = 5'd5;
  logic [4:0]  frame_h = 5'd4;
  logic [CW-1:0] skip_thresh = '0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [4:0]  start_x = '0;
  logic [4:0]  start_y = '0;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_mode;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [CW-1:0] rsp_cost;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [2:0]  res_mode;
  logic [CW-1:0] res_cost;

  always #4 clk = ~clk;

  mb_mode_selector uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .frame_w(frame_w), .frame_h(frame_h), .skip_thresh(skip_thresh),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_x(start_x), .start_y(start_y),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_cost(rsp_cost),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_mode(res_mode), .res_cost(res_cost)
  );

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  int  cost_tab [8];
  logic [7:0] req_mask = '0;
  int  dup_cnt = 0;
  int  first_req = -1;
  bit  stall_en = 1'b0;

  int  fw = 5, fh = 4, t1 = 0;
  int  cm [22][18];
  int  cc [22][18];
  int  pm [22][18];
  int  pc [22][18];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cost engine model: one response the cycle after each accepted request
  initial begin
    rsp_valid = 1'b0;
    rsp_cost  = '0;
    req_ready = 1'b1;
    forever begin
      @(posedge clk);
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        if (req_mask == '0) first_req = int'(req_mode);
        if (req_mask[req_mode]) dup_cnt++;
        req_mask[req_mode] = 1'b1;
        rsp_valid <= 1'b1;
        rsp_cost  <= CW'(cost_tab[req_mode]);
      end
      req_ready <= stall_en ? ~req_ready : 1'b1;
    end
  end

  // behavioural model of the decision rules
  task automatic ref_mb(input int x, input int y, output int em, output int ec,
                        output int emask, output string ptag);
    int m;
    int t2;
    bit done;
    done  = 1'b0;
    emask = 1;
    em    = 0;
    ec    = cost_tab[0];
    ptag  = "R1 skip";
    if (cost_tab[0] < t1) done = 1'b1;
    if (!done && (x == 0 || y == 0)) begin
      ptag = "R2 edge";
      emask = 8'h7f;
      em = 0; ec = cost_tab[0];
      for (int i = 1; i < 7; i++) if (cost_tab[i] < ec) begin em = i; ec = cost_tab[i]; end
      done = 1'b1;
    end
    if (!done && x + 1 < fw && cm[x-1][y] == cm[x][y-1] && cm[x][y-1] == cm[x+1][y-1]) begin
      m  = cm[x-1][y];
      t2 = (cc[x-1][y] + cc[x][y-1] + cc[x+1][y-1]) / 3;
      emask |= (1 << m);
      if (cost_tab[m] < t2) begin em = m; ec = cost_tab[m]; ptag = "R3 spatial"; done = 1'b1; end
    end
    if (!done && x + 1 < fw && y + 1 < fh && pm[x][y+1] == pm[x+1][y]) begin
      m  = pm[x][y+1];
      t2 = (pc[x][y+1] + pc[x+1][y]) / 2;
      emask |= (1 << m);
      if (cost_tab[m] < t2) begin em = m; ec = cost_tab[m]; ptag = "R4 temporal R8"; done = 1'b1; end
    end
    if (!done) begin
      ptag = "R5 full";
      emask = 8'h7f;
      em = 0; ec = cost_tab[0];
      for (int i = 1; i < 7; i++) if (cost_tab[i] < ec) begin em = i; ec = cost_tab[i]; end
    end
    cm[x][y] = em;
    cc[x][y] = ec;
  endtask

  task automatic run_mb(input int x, input int y, input string xtag);
    int em, ec, emask;
    string ptag;
    bit got;
    logic [2:0] hm;
    logic [CW-1:0] hc;
    ref_mb(x, y, em, ec, emask, ptag);
    @(negedge clk);
    req_mask = '0; dup_cnt = 0; first_req = -1;
    start_x = 5'(x); start_y = 5'(y); start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (res_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, {ptag, " result appears", xtag}, int'(got), 1);
    chk(res_mode == 3'(em), {ptag, " mode R7", xtag}, int'(res_mode), em);
    chk(res_cost == CW'(ec), {ptag, " cost", xtag}, int'(res_cost), ec);
    chk(req_mask == 8'(emask), {ptag, " modes priced", xtag}, int'(req_mask), emask);
    chk(dup_cnt == 0, {"R6 repeated request", xtag}, dup_cnt, 0);
    chk(first_req == 0, {"R1 first request is skip", xtag}, first_req, 0);
    hm = res_mode; hc = res_cost;
    @(negedge clk);
    chk(res_valid && res_mode == hm && res_cost == hc, "R10 result held",
        int'(res_mode), int'(hm));
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(start_ready && !res_valid, "R10 idle after accept", int'(start_ready), 1);
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int x = 0; x < 22; x++)
      for (int y = 0; y < 18; y++) begin
        pm[x][y] = cm[x][y];
        pc[x][y] = cc[x][y];
      end
  endtask

  task automatic set_costs(input int pat, input int x, input int y);
    for (int m = 0; m < 8; m++) begin
      case (pat)
        0: cost_tab[m] = (m == 0) ? 400 : (m == 1) ? 150 - 3 * (y * fw + x) : 300 + m;
        1: cost_tab[m] = (m == 0) ? 400 : (m == 1) ? 60 : 300;
        2: cost_tab[m] = 40 + ((x * 7 + y * 13 + m * 5 + 3) % 17) * 9;
        3: cost_tab[m] = 500 + m;
        4: cost_tab[m] = 30 + ((x * 11 + y * 3 + m * 7 + 1) % 19) * 8;
        5: cost_tab[m] = 500;
        default: cost_tab[m] = (m == 0) ? 77 : (m == 1) ? 90 : 200;
      endcase
    end
  endtask

  task automatic run_frame(input int pat, input int thr, input int w, input int h,
                           input bit stall, input string xtag);
    pulse_frame();
    fw = w; fh = h; t1 = thr;
    frame_w = 5'(w); frame_h = 5'(h); skip_thresh = CW'(thr);
    stall_en = stall;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        set_costs(pat, x, y);
        run_mb(x, y, xtag);
      end
    stall_en = 1'b0;
  endtask

  task automatic test_reset();
    chk(start_ready == 1'b1, "reset start_ready", int'(start_ready), 1);
    chk(req_valid == 1'b0, "reset req_valid R9", int'(req_valid), 0);
    chk(res_valid == 1'b0, "reset res_valid R10", int'(res_valid), 0);
    chk(rsp_ready == 1'b0, "reset rsp_ready", int'(rsp_ready), 0);
  endtask

  // gradient: costs fall in raster order so spatial agreement is accepted
  task automatic test_spatial_frame();
    run_frame(0, 50, 5, 4, 1'b0, " [gradient, R3]");
  endtask

  // equal neighbour costs: strict spatial compare fails, previous frame accepted (R8 swap)
  task automatic test_temporal_frame();
    run_frame(1, 50, 5, 4, 1'b0, " [previous frame, R4 R8]");
  endtask

  task automatic test_mixed_frame();
    run_frame(2, 60, 5, 4, 1'b0, " [mixed]");
  endtask

  task automatic test_skip_frame();
    run_frame(3, 1000, 5, 4, 1'b0, " [all skip, R1]");
  endtask

  task automatic test_backpressure_frame();
    run_frame(4, 55, 5, 4, 1'b1, " [req stall, R9]");
  endtask

  task automatic test_tie_frame();
    run_frame(5, 10, 5, 4, 1'b0, " [equal costs, R2 R5 tie]");
  endtask

  task automatic test_threshold_equal();
    run_frame(6, 77, 3, 2, 1'b0, " [skip cost equals threshold, R1]");
  endtask

  task automatic test_small_frame();
    run_frame(2, 45, 3, 2, 1'b0, " [3x2 frame]");
  endtask

  initial begin
    for (int x = 0; x < 22; x++)
      for (int y = 0; y < 18; y++) begin
        cm[x][y] = 0; cc[x][y] = 0; pm[x][y] = 0; pc[x][y] = 0;
      end
    for (int m = 0; m < 8; m++) cost_tab[m] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_spatial_frame();
    test_temporal_frame();
    test_mixed_frame();
    test_skip_frame();
    test_backpressure_frame();
    test_tie_frame();
    test_threshold_equal();
    test_small_frame();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule